// File: doc/BRIEF.md
# Subcarrier Envelope Demodulator and Manchester Frame Decoder

This block takes a stream of amplitude samples of a load-modulated tag response and turns it into decoded bytes. Each sample is compared with a programmable decision level widened by a dead band on both sides. A short majority vote over the most recent samples sets a level flag, and every flip of that flag is an edge. Edges retrigger a hold timer. The timer's output is the recovered baseband: high while subcarrier activity is present and low during unmodulated stretches. The hold time is set longer than the spacing between subcarrier edges, so the timer bridges the gaps inside a burst of modulation.

A frame decoder follows the baseband. A rising baseband from idle starts the frame header. After the header, each Manchester symbol is sampled at one quarter and at three quarters of its length. Bits are packed into bytes least significant bit first. A CRC-16 runs over every completed byte. A symbol whose two samples agree closes the frame. At that point a pass or fail flag is published, and it holds until the next frame closes.

All timing is counted in valid samples, so the sample rate may be lower than the clock rate. The decision level, the dead band, the hold length and the samples per bit are inputs. They are expected to stay constant while a frame is in progress.

Top module: `subcarrier_env_decoder`

## Requirements
- R1: After reset, baseband, byte valid and frame end are low. The CRC flag is low and the internal level flag starts in the high (unmodulated) state.
- R2: A valid sample counts as high when it is strictly above threshold+margin and as low when it is strictly below threshold−margin. Samples inside the band count as neither. The level flag turns high (or low) once at least 3 of the last 5 valid samples count as high (or low). Every flip of the level flag is one edge.
- R3: An edge reloads the hold counter with hold_len on the next clock. The counter then decrements on each valid sample, and baseband is high while the counter is nonzero. With samples valid on every clock, two edges three samples apart keep baseband high for exactly hold_len+3 clocks.
- R4: A baseband rise while idle starts a header that lasts 1.5 bit times. Baseband must be high at the 0.75 bit point of the header. The first symbol after the header must decode as 1. If either test fails, the decoder returns to idle with no output.
- R5: Each symbol is spb samples long. It is sampled at sample index spb/4 and at spb−spb/4. The pair (high, low) decodes to 0 and (low, high) decodes to 1.
- R6: Decoded bits fill bytes least significant bit first. Each completed byte produces a one-clock byte valid pulse with the byte on the data output.
- R7: A symbol whose two samples are equal gives a one-clock frame end pulse and returns the decoder to idle. Bits of an unfinished byte are dropped.
- R8: The CRC register is preset to 0xFFFF before the first data byte. Each completed byte is shifted in least significant bit first with reflected polynomial 0x8408. The CRC flag is set at frame end when all of these hold: the register equals residue 0xF0B8, at least two bytes were received, and exactly one 0 bit is pending. The flag changes only at frame end.
- R9: Clock cycles without sample valid have no effect on decoding. A frame sent with gaps between samples decodes the same as one sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | SAMPLE_W | Amplitude sample |
| smp_valid_i | input | 1 | Sample valid |
| thresh_i | input | SAMPLE_W | Decision level, same format as samples |
| margin_i | input | SAMPLE_W | Dead band half-width, unsigned |
| hold_len_i | input | HOLD_W | Hold time in samples |
| spb_i | input | SPB_W | Samples per bit |
| baseband_o | output | 1 | Recovered baseband |
| byte_valid_o | output | 1 | Decoded byte strobe |
| byte_o | output | 8 | Decoded byte |
| frame_end_o | output | 1 | Frame closed strobe |
| crc_ok_o | output | 1 | CRC pass flag of the last frame |

## Verification
The assertions assume that spb_i, hold_len_i, threshold and margin stay constant while a frame is being decoded. They also assume spb_i is at least 8, so the two symbol sample points differ. The stimulus therefore sets the configuration between frames only, while the line is idle. The hold length is changed in a burst-only test, not during a frame. The modulated halves use a subcarrier of four samples, and the hold length exceeds the spacing between edges. This keeps the recovered baseband high across each modulated half and lets it fall before the next sample point.

// File: rtl/sced_pkg.sv
package sced_pkg;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_HEAD = 2'd1,
        DS_SYM  = 2'd2
    } dec_state_e;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE   = 16'hF0B8;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] d_in);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d_in[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/sced_level_tracker.sv
module sced_level_tracker #(
    parameter int SAMPLE_W       = 12,
    parameter int WIN            = 5,
    parameter bit SIGNED_SAMPLES = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                valid_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    input  logic [SAMPLE_W-1:0] margin_i,
    output logic                level_o,
    output logic                edge_o
);
    localparam int VOTE  = WIN / 2 + 1;
    localparam int CNT_W = $clog2(WIN + 1);
    localparam int HIST  = WIN - 1;

    typedef struct packed {
        logic [HIST-1:0] hi_hist;
        logic [HIST-1:0] lo_hist;
        logic            level;
        logic            edge_p;
    } trk_s;

    trk_s q, d;

    logic [SAMPLE_W-1:0] smp_u, thr_u;
    logic                is_hi, is_lo;
    logic [WIN-1:0]      hi_win, lo_win;
    logic [CNT_W-1:0]    n_hi, n_lo;

    // Map signed samples to offset binary so one unsigned compare serves both
    generate
        if (SIGNED_SAMPLES) begin : g_signed
            assign smp_u = {~smp_i[SAMPLE_W-1],    smp_i[SAMPLE_W-2:0]};
            assign thr_u = {~thresh_i[SAMPLE_W-1], thresh_i[SAMPLE_W-2:0]};
        end else begin : g_unsigned
            assign smp_u = smp_i;
            assign thr_u = thresh_i;
        end
    endgenerate

    always_comb begin
        is_hi  = {1'b0, smp_u} > ({1'b0, thr_u} + {1'b0, margin_i});
        is_lo  = ({1'b0, smp_u} + {1'b0, margin_i}) < {1'b0, thr_u};
        hi_win = {q.hi_hist, is_hi};
        lo_win = {q.lo_hist, is_lo};
        n_hi   = '0;
        n_lo   = '0;
        for (int i = 0; i < WIN; i++) begin
            n_hi = n_hi + CNT_W'(hi_win[i]);
            n_lo = n_lo + CNT_W'(lo_win[i]);
        end

        d        = q;
        d.edge_p = 1'b0;
        if (valid_i) begin
            d.hi_hist = hi_win[HIST-1:0];
            d.lo_hist = lo_win[HIST-1:0];
            if (n_hi >= CNT_W'(VOTE))      d.level = 1'b1;
            else if (n_lo >= CNT_W'(VOTE)) d.level = 1'b0;
            d.edge_p = (d.level != q.level);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.hi_hist <= '0;
            q.lo_hist <= '0;
            q.level   <= 1'b1;
            q.edge_p  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.level;
    assign edge_o  = q.edge_p;

    AST_LEVEL_HOLDS_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(level_o)); // R2
    AST_EDGE_MEANS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (level_o != $past(level_o))); // R2

endmodule

// File: rtl/sced_hold_timer.sv
module sced_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              tick_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              bb_o
);
    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } hold_s;

    hold_s q, d;

    always_comb begin
        d = q;
        if (edge_i)                      d.cnt = hold_len_i;
        else if (tick_i && q.cnt != '0)  d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.cnt <= '0;
        else        q <= d;
    end

    assign bb_o = (q.cnt != '0);

    AST_EDGE_RAISES_BB: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && hold_len_i != '0) |=> bb_o); // R3
    AST_BB_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bb_o) |-> $past(edge_i)); // R3

endmodule

// File: rtl/sced_frame_decoder.sv
module sced_frame_decoder
    import sced_pkg::*;
#(
    parameter int SPB_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             bb_i,
    input  logic [SPB_W-1:0] spb_i,
    output logic             byte_valid_o,
    output logic [7:0]       byte_o,
    output logic             frame_end_o,
    output logic             crc_ok_o
);
    localparam int CW = SPB_W + 1;

    typedef struct packed {
        dec_state_e  st;
        logic [CW-1:0] cnt;
        logic        bb_prev;
        logic        first;
        logic        s1;
        logic [7:0]  sr;
        logic [2:0]  bitcnt;
        logic [1:0]  nbytes;
        logic [15:0] crc;
        logic        byte_valid;
        logic [7:0]  byte_data;
        logic        frame_end;
        logic        crc_ok;
    } dec_s;

    dec_s q, d;

    logic [CW-1:0] spb_x, q1, q3, sym_last, head_last;
    logic          ok_now;

    always_comb begin
        spb_x     = {1'b0, spb_i};
        q1        = spb_x >> 2;
        q3        = spb_x - q1;
        sym_last  = spb_x - 1'b1;
        head_last = spb_x + (spb_x >> 1) - 1'b1;
        ok_now    = (q.crc == CRC_RESIDUE) && (q.bitcnt == 3'd1) &&
                    !q.sr[7] && (q.nbytes == 2'd2);

        d            = q;
        d.byte_valid = 1'b0;
        d.frame_end  = 1'b0;
        if (tick_i) begin
            d.bb_prev = bb_i;
            case (q.st)
                DS_IDLE: begin
                    if (bb_i && !q.bb_prev) begin
                        d.st  = DS_HEAD;
                        d.cnt = '0;
                    end
                end
                DS_HEAD: begin
                    if (q.cnt == q3 && !bb_i) begin
                        d.st = DS_IDLE;
                    end else if (q.cnt == head_last) begin
                        d.st     = DS_SYM;
                        d.cnt    = '0;
                        d.first  = 1'b1;
                        d.bitcnt = '0;
                        d.nbytes = '0;
                        d.crc    = CRC_PRESET;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                DS_SYM: begin
                    d.cnt = (q.cnt == sym_last) ? '0 : q.cnt + 1'b1;
                    if (q.cnt == q1) d.s1 = bb_i;
                    if (q.cnt == q3) begin
                        if (q.s1 == bb_i) begin
                            d.st = DS_IDLE;
                            if (!q.first) begin
                                d.frame_end = 1'b1;
                                d.crc_ok    = ok_now;
                            end
                        end else if (q.first) begin
                            d.first = 1'b0;
                            if (!bb_i) d.st = DS_IDLE;
                        end else begin
                            d.sr     = {bb_i, q.sr[7:1]};
                            d.bitcnt = q.bitcnt + 1'b1;
                            if (q.bitcnt == 3'd7) begin
                                d.byte_valid = 1'b1;
                                d.byte_data  = d.sr;
                                d.crc        = crc16_byte(q.crc, d.sr);
                                if (q.nbytes != 2'd2) d.nbytes = q.nbytes + 1'b1;
                            end
                        end
                    end
                end
                default: d.st = DS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st         <= DS_IDLE;
            q.cnt        <= '0;
            q.bb_prev    <= 1'b0;
            q.first      <= 1'b0;
            q.s1         <= 1'b0;
            q.sr         <= '0;
            q.bitcnt     <= '0;
            q.nbytes     <= '0;
            q.crc        <= CRC_PRESET;
            q.byte_valid <= 1'b0;
            q.byte_data  <= '0;
            q.frame_end  <= 1'b0;
            q.crc_ok     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign byte_valid_o = q.byte_valid;
    assign byte_o       = q.byte_data;
    assign frame_end_o  = q.frame_end;
    assign crc_ok_o     = q.crc_ok;

    AST_NO_BYTE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid_o && frame_end_o)); // R7
    AST_CRC_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_o |-> $stable(crc_ok_o)); // R8
    AST_SYM_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == DS_SYM) |-> (q.cnt < spb_x)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == DS_IDLE && $past(q.st) == DS_IDLE) |-> !byte_valid_o); // R6

endmodule

// File: rtl/subcarrier_env_decoder.sv
module subcarrier_env_decoder #(
    parameter int SAMPLE_W       = 12,
    parameter bit SIGNED_SAMPLES = 1'b0,
    parameter int WIN            = 5,
    parameter int HOLD_W         = 8,
    parameter int SPB_W          = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    input  logic [SAMPLE_W-1:0] margin_i,
    input  logic [HOLD_W-1:0]   hold_len_i,
    input  logic [SPB_W-1:0]    spb_i,
    output logic                baseband_o,
    output logic                byte_valid_o,
    output logic [7:0]          byte_o,
    output logic                frame_end_o,
    output logic                crc_ok_o
);
    logic level_w, edge_w, bb_w;

    sced_level_tracker #(
        .SAMPLE_W(SAMPLE_W), .WIN(WIN), .SIGNED_SAMPLES(SIGNED_SAMPLES)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .valid_i(smp_valid_i),
        .thresh_i(thresh_i), .margin_i(margin_i),
        .level_o(level_w), .edge_o(edge_w)
    );

    sced_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .tick_i(smp_valid_i),
        .hold_len_i(hold_len_i), .bb_o(bb_w)
    );

    sced_frame_decoder #(.SPB_W(SPB_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .tick_i(smp_valid_i), .bb_i(bb_w),
        .spb_i(spb_i), .byte_valid_o(byte_valid_o), .byte_o(byte_o),
        .frame_end_o(frame_end_o), .crc_ok_o(crc_ok_o)
    );

    assign baseband_o = bb_w;

    AST_RESET_LEVEL_HIGH: assert property (@(posedge clk)
        $rose(rst_n) |-> level_w); // R1

endmodule

// File: tb/subcarrier_env_decoder_bench.sv
`timescale 1ns/1ps
module subcarrier_env_decoder_bench;
    localparam int HI = 200;
    localparam int LO = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp = 12'd200;
    logic        vld = 1'b0;
    logic [11:0] thr = 12'd150;
    logic [11:0] mar = 12'd20;
    logic [7:0]  hold = 8'd5;
    logic [9:0]  spb = 10'd40;
    logic        bb, bv, fe, ok;
    logic [7:0]  bd;

    int checks = 0, errors = 0;
    bit gap = 1'b0;
    bit done = 1'b0;

    int      nb = 0, nfe = 0, bbcnt = 0;
    logic [7:0] rx [0:15];
    logic       last_ok = 1'b0;
    logic [7:0] tx [0:7];
    int      tx_n = 0;

    always #2 clk = ~clk;

    subcarrier_env_decoder u_subcarrier_env_decoder (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_valid_i(vld),
        .thresh_i(thr), .margin_i(mar), .hold_len_i(hold), .spb_i(spb),
        .baseband_o(bb), .byte_valid_o(bv), .byte_o(bd),
        .frame_end_o(fe), .crc_ok_o(ok)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (bv) begin
                if (nb < 16) rx[nb] = bd;
                nb = nb + 1;
            end
            if (fe) begin
                nfe = nfe + 1;
                last_ok = ok;
            end
            if (bb) bbcnt = bbcnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nb = 0; nfe = 0; bbcnt = 0;
    endtask

    task automatic put(input int v);
        @(negedge clk);
        smp = 12'(v);
        vld = 1'b1;
        if (gap) begin
            @(negedge clk);
            vld = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(HI);
    endtask

    task automatic half(input bit modulated);
        for (int i = 0; i < int'(spb) / 2; i++)
            put(modulated ? (((i % 4) < 2) ? LO : HI) : HI);
    endtask

    task automatic sym(input bit b);
        if (b) begin half(1'b0); half(1'b1); end
        else   begin half(1'b1); half(1'b0); end
    endtask

    task automatic sof();
        idle(60);
        half(1'b1); half(1'b1); half(1'b1);
        sym(1'b1);
    endtask

    task automatic eof();
        sym(1'b0);
        half(1'b1); half(1'b1); half(1'b1);
        idle(100);
    endtask

    task automatic add_crc();
        logic [15:0] c;
        c = 16'hFFFF;
        for (int k = 0; k < tx_n; k++)
            for (int i = 0; i < 8; i++)
                c = ((c[0] ^ tx[k][i]) != 1'b0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        c = ~c;
        tx[tx_n] = c[7:0];
        tx[tx_n + 1] = c[15:8];
        tx_n = tx_n + 2;
    endtask

    task automatic send_frame();
        sof();
        for (int k = 0; k < tx_n; k++)
            for (int i = 0; i < 8; i++) sym(tx[k][i]);
        eof();
    endtask

    task automatic check_bytes(input string req);
        chk(req, nb, tx_n);
        for (int k = 0; k < tx_n && k < nb; k++) chk(req, int'(rx[k]), int'(tx[k]));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 baseband", int'(bb), 0);
        chk("R1 byte_valid", int'(bv), 0);
        chk("R1 frame_end", int'(fe), 0);
        chk("R1 crc_ok", int'(ok), 0);
    endtask

    task automatic t_margin();
        clear_mon();
        idle(20);
        for (int i = 0; i < 100; i++) put((i % 2) ? 165 : 135);
        for (int i = 0; i < 3; i++) put(130);
        idle(60);
        chk("R2 in-band samples give no baseband", bbcnt, 0);
        chk("R2 no bytes", nb, 0);
    endtask

    task automatic burst(input int low_val);
        clear_mon();
        idle(20);
        for (int i = 0; i < 3; i++) put(low_val);
        idle(100);
    endtask

    task automatic t_hold();
        hold = 8'd5;
        burst(129);
        chk("R2 sample just below band edges", bbcnt, 8);
        chk("R4 aborted header gives no frame end", nfe, 0);
        burst(LO);
        chk("R3 hold 5 retrigger width", bbcnt, 8);
        hold = 8'd9;
        burst(LO);
        chk("R3 hold 9 retrigger width", bbcnt, 12);
        hold = 8'd5;
    endtask

    task automatic t_frame_ok();
        clear_mon();
        tx[0] = 8'h01; tx[1] = 8'h5A; tx_n = 2;
        add_crc();
        send_frame();
        check_bytes("R5 R6 good frame bytes");
        chk("R7 one frame end", nfe, 1);
        chk("R8 crc pass", int'(last_ok), 1);
        chk("R8 flag held after frame", int'(ok), 1);
    endtask

    task automatic t_frame_bad();
        clear_mon();
        tx[0] = 8'h01; tx[1] = 8'h5A; tx_n = 2;
        add_crc();
        tx[2] = tx[2] ^ 8'h10;
        send_frame();
        check_bytes("R6 corrupted frame bytes");
        chk("R7 frame end on bad crc", nfe, 1);
        chk("R8 crc fail", int'(last_ok), 0);
    endtask

    task automatic t_violation();
        clear_mon();
        sof();
        for (int i = 0; i < 8; i++) sym(((8'hA5 >> i) & 1) != 0);
        sym(1'b1); sym(1'b0);
        half(1'b0); half(1'b0);
        idle(100);
        chk("R7 bytes before violation", nb, 1);
        chk("R7 byte value", int'(rx[0]), 8'hA5);
        chk("R7 frame end on violation", nfe, 1);
        chk("R8 fail with partial byte", int'(last_ok), 0);
    endtask

    task automatic t_bad_sof();
        clear_mon();
        idle(60);
        half(1'b1); half(1'b1); half(1'b1);
        sym(1'b0);
        idle(140);
        chk("R4 first symbol 0 gives no bytes", nb, 0);
        chk("R4 first symbol 0 gives no frame end", nfe, 0);
    endtask

    task automatic t_gaps();
        clear_mon();
        gap = 1'b1;
        tx[0] = 8'hC3; tx[1] = 8'h00; tx[2] = 8'hFF; tx_n = 3;
        add_crc();
        send_frame();
        gap = 1'b0;
        check_bytes("R9 gapped frame bytes");
        chk("R9 gapped frame end", nfe, 1);
        chk("R9 gapped crc pass", int'(last_ok), 1);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_margin();
        t_hold();
        t_frame_ok();
        t_frame_bad();
        t_violation();
        t_bad_sof();
        t_gaps();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule